// File: doc/BRIEF.md
# Outbound I/O Window Address Translator

This block watches requests on an internal bus whose addresses are 36 bits wide. It decides whether each one falls inside a single 64 KB window reserved for outbound I/O. When a valid request lands in the window, the block claims it in the same cycle. For every valid request it also forms a 32-bit downstream I/O address. The low 16 bits of that address pass straight through from the request. The upper 16 bits come from a software-programmed translate value.

Two 32-bit registers sit behind a plain register port: a window base register and a translate value register. The base register holds two things. Its upper 20 bits place the window in the internal space, and its low 3 bits hold a function number. The block presents that function number on every outbound cycle so the far side can build the requester identifier. A register write takes effect on the very next request, with no shadow copy.

Top module: `oio_window_xlate`

## Requirements
- R1: `claim` is 1 in the same cycle as `req_valid`=1 exactly when `req_addr[35:16]` equals base register bits 31:12; otherwise `claim` is 0.
- R2: While `req_valid`=1, `io_addr[15:0]` equals `req_addr[15:0]`, whether or not the request is claimed.
- R3: While `req_valid`=1, `io_addr[31:16]` equals translate register bits 31:16.
- R4: `func_num` always equals base register bits 2:0.
- R5: Base register bits 11:3 read as zero, and values written to them are discarded.
- R6: After reset the base register reads 0xFFFFD000, the translate register reads 0x00000000, `claim` is 0 and `io_addr` is 0.
- R7: The base register is at offset 0x300 and the translate register is at offset 0x304. Only translate bits 31:16 are stored; its bits 15:0 read as zero.
- R8: A read of any other offset (for example 0x308) returns zero, and a write there changes no register.
- R9: While `req_valid`=0, `claim` is 0 and `io_addr` keeps the value it had for the most recent valid request.
- R10: A register write completed at one clock edge governs a request presented in the cycle right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 12 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_we | input | 1 | Register write strobe, sampled at the clock edge |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| req_valid | input | 1 | Internal request valid |
| req_addr | input | 36 | Internal request address |
| claim | output | 1 | Request falls in the window and is taken |
| io_addr | output | 32 | Downstream I/O address |
| func_num | output | 3 | Function number for the requester identifier |

## Verification
The bench builds the block with its default parameters: a 36-bit internal address, a 16-bit window offset, 32-bit registers and a 3-bit function field. With these values the bench's field positions match the register layout exactly. It can therefore reach several cases: the 0xFFFFD reset window, the first and last offsets of a relocated window, misses that differ only in the top address bit or in the next window up, and a write to the reserved base bits. Because the registers are 12-bit decoded, a neighbouring unmapped offset such as 0x308 tests the decode boundary. The bench also presents a request in the cycle right after a write to show that the new value takes effect at once.

// File: rtl/oio_pkg.sv
package oio_pkg;

   typedef enum logic [1:0] {
      SEL_NONE  = 2'd0,
      SEL_BASE  = 2'd1,
      SEL_XLATE = 2'd2
   } oio_sel_e;

   localparam int unsigned OIO_BASE_OFS  = 'h300;
   localparam int unsigned OIO_XLATE_OFS = 'h304;
   localparam int unsigned OIO_BASE_RST  = 'hFFFFD;

endpackage

// File: rtl/oio_regfile.sv
module oio_regfile
   import oio_pkg::*;
#(
   parameter int unsigned REG_W     = 32,
   parameter int unsigned REG_AW    = 12,
   parameter int unsigned FLD_W     = 20,
   parameter int unsigned FN_W      = 3,
   parameter int unsigned OADDR_W   = 32,
   parameter int unsigned WIN_BITS  = 16,
   parameter int unsigned BASE_OFS  = OIO_BASE_OFS,
   parameter int unsigned XLATE_OFS = OIO_XLATE_OFS,
   parameter int unsigned BASE_RST  = OIO_BASE_RST
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [REG_AW-1:0]           reg_addr,
   input  logic [REG_W-1:0]            reg_wdata,
   input  logic                        reg_we,
   output logic [REG_W-1:0]            reg_rdata,
   output logic [FLD_W-1:0]            base_fld,
   output logic [FN_W-1:0]             fn_num,
   output logic [OADDR_W-WIN_BITS-1:0] xl_fld
);
   localparam int unsigned XL_W = OADDR_W - WIN_BITS;

   oio_sel_e sel;
   logic     unused_wd;

   assign unused_wd = ^reg_wdata;

   always_comb begin
      if (reg_addr == REG_AW'(BASE_OFS))
         sel = SEL_BASE;
      else if (reg_addr == REG_AW'(XLATE_OFS))
         sel = SEL_XLATE;
      else
         sel = SEL_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_fld <= FLD_W'(BASE_RST);
         fn_num   <= '0;
         xl_fld   <= '0;
      end else if (reg_we) begin
         case (sel)
            SEL_BASE: begin
               base_fld <= reg_wdata[REG_W-1 -: FLD_W];
               fn_num   <= reg_wdata[FN_W-1:0];
            end
            SEL_XLATE: xl_fld <= reg_wdata[OADDR_W-1 -: XL_W];
            default: ;
         endcase
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (sel)
         SEL_BASE: begin
            reg_rdata[REG_W-1 -: FLD_W] = base_fld;
            reg_rdata[FN_W-1:0]         = fn_num;
         end
         SEL_XLATE: reg_rdata[OADDR_W-1 -: XL_W] = xl_fld;
         default: reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/oio_match.sv
module oio_match #(
   parameter int unsigned IADDR_W  = 36,
   parameter int unsigned WIN_BITS = 16
) (
   input  logic                         req_valid,
   input  logic [IADDR_W-1:WIN_BITS]    req_hi,
   input  logic [IADDR_W-WIN_BITS-1:0]  base_fld,
   output logic                         hit
);
   assign hit = req_valid && (req_hi == base_fld);
endmodule

// File: rtl/oio_xlate.sv
module oio_xlate #(
   parameter int unsigned OADDR_W  = 32,
   parameter int unsigned WIN_BITS = 16
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        req_valid,
   input  logic [WIN_BITS-1:0]         req_lo,
   input  logic [OADDR_W-WIN_BITS-1:0] xl_fld,
   output logic [OADDR_W-1:0]          io_addr
);
   logic [OADDR_W-1:0] fresh;
   logic [OADDR_W-1:0] held_q;

   generate
      if (OADDR_W > WIN_BITS) begin : g_subst
         assign fresh = {xl_fld, req_lo};
      end else begin : g_pass
         assign fresh = OADDR_W'(req_lo);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         held_q <= '0;
      else if (req_valid)
         held_q <= fresh;
   end

   assign io_addr = req_valid ? fresh : held_q;
endmodule

// File: rtl/oio_window_xlate.sv
module oio_window_xlate
   import oio_pkg::*;
#(
   parameter int unsigned IADDR_W   = 36,
   parameter int unsigned OADDR_W   = 32,
   parameter int unsigned WIN_BITS  = 16,
   parameter int unsigned REG_W     = 32,
   parameter int unsigned REG_AW    = 12,
   parameter int unsigned FN_W      = 3,
   parameter int unsigned BASE_OFS  = OIO_BASE_OFS,
   parameter int unsigned XLATE_OFS = OIO_XLATE_OFS,
   parameter int unsigned BASE_RST  = OIO_BASE_RST
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [REG_AW-1:0]  reg_addr,
   input  logic [REG_W-1:0]   reg_wdata,
   input  logic               reg_we,
   output logic [REG_W-1:0]   reg_rdata,
   input  logic               req_valid,
   input  logic [IADDR_W-1:0] req_addr,
   output logic               claim,
   output logic [OADDR_W-1:0] io_addr,
   output logic [FN_W-1:0]    func_num
);
   localparam int unsigned FLD_W = IADDR_W - WIN_BITS;
   localparam int unsigned XL_W  = OADDR_W - WIN_BITS;

   generate
      if (IADDR_W <= WIN_BITS) begin : g_bad_iaddr
         $error("IADDR_W must exceed WIN_BITS");
      end
      if (OADDR_W <= WIN_BITS || OADDR_W > REG_W) begin : g_bad_oaddr
         $error("OADDR_W must exceed WIN_BITS and fit in REG_W");
      end
      if (FLD_W + FN_W > REG_W) begin : g_bad_fields
         $error("base field and function number overlap");
      end
      if (BASE_OFS == XLATE_OFS) begin : g_bad_ofs
         $error("register offsets collide");
      end
   endgenerate

   logic [FLD_W-1:0] base_fld;
   logic [XL_W-1:0]  xl_fld;

   oio_regfile #(
      .REG_W(REG_W), .REG_AW(REG_AW), .FLD_W(FLD_W), .FN_W(FN_W),
      .OADDR_W(OADDR_W), .WIN_BITS(WIN_BITS), .BASE_OFS(BASE_OFS),
      .XLATE_OFS(XLATE_OFS), .BASE_RST(BASE_RST)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_we(reg_we), .reg_rdata(reg_rdata), .base_fld(base_fld),
      .fn_num(func_num), .xl_fld(xl_fld)
   );

   oio_match #(.IADDR_W(IADDR_W), .WIN_BITS(WIN_BITS)) u_match (
      .req_valid(req_valid), .req_hi(req_addr[IADDR_W-1:WIN_BITS]),
      .base_fld(base_fld), .hit(claim)
   );

   oio_xlate #(.OADDR_W(OADDR_W), .WIN_BITS(WIN_BITS)) u_xlate (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
      .req_lo(req_addr[WIN_BITS-1:0]), .xl_fld(xl_fld), .io_addr(io_addr)
   );
endmodule

// File: rtl/oio_window_xlate_chk.sv
module oio_window_xlate_chk #(
   parameter int unsigned IADDR_W  = 36,
   parameter int unsigned OADDR_W  = 32,
   parameter int unsigned WIN_BITS = 16,
   parameter int unsigned REG_W    = 32,
   parameter int unsigned REG_AW   = 12,
   parameter int unsigned FN_W     = 3,
   parameter int unsigned BASE_OFS = 'h300
) (
   input logic               clk,
   input logic               rst_n,
   input logic [REG_AW-1:0]  reg_addr,
   input logic [REG_W-1:0]   reg_wdata,
   input logic               reg_we,
   input logic [REG_W-1:0]   reg_rdata,
   input logic               req_valid,
   input logic [IADDR_W-1:0] req_addr,
   input logic               claim,
   input logic [OADDR_W-1:0] io_addr,
   input logic [FN_W-1:0]    func_num
);
   localparam int unsigned FLD_W = IADDR_W - WIN_BITS;

   logic unused_chk;
   assign unused_chk = ^reg_wdata;

   AST_CLAIM_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      claim |-> req_valid); // R1
   AST_LOW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> io_addr[WIN_BITS-1:0] == req_addr[WIN_BITS-1:0]); // R2
   AST_FN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && reg_addr == REG_AW'(BASE_OFS)) |=> $stable(func_num)); // R4
   AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      reg_addr == REG_AW'(BASE_OFS) |-> reg_rdata[REG_W-FLD_W-1:FN_W] == '0); // R5
   AST_IDLE_NO_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> !claim); // R9
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> $stable(io_addr)); // R9
endmodule

bind oio_window_xlate oio_window_xlate_chk #(
   .IADDR_W(IADDR_W), .OADDR_W(OADDR_W), .WIN_BITS(WIN_BITS),
   .REG_W(REG_W), .REG_AW(REG_AW), .FN_W(FN_W), .BASE_OFS(BASE_OFS)
) u_chk (.*);

// File: tb/tb_oio_window_xlate.sv
module tb_oio_window_xlate;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic        reg_we = 1'b0;
   logic [31:0] reg_rdata;
   logic        req_valid = 1'b0;
   logic [35:0] req_addr = '0;
   logic        claim;
   logic [31:0] io_addr;
   logic [2:0]  func_num;

   int total = 0;
   int bad = 0;

   logic [19:0] m_base = 20'hFFFFD;
   logic [2:0]  m_fn = '0;
   logic [15:0] m_xl = '0;
   logic [31:0] m_hold = '0;

   logic        q_claim[$];
   logic [31:0] q_io[$];
   logic [2:0]  q_fn[$];
   string       q_tag[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   oio_window_xlate dut (.*);

   // monitor: compares one expected item per cycle it was pushed
   always @(negedge clk) begin
      if (q_claim.size() > 0) begin
         logic        ec;
         logic [31:0] ei;
         logic [2:0]  ef;
         string       t;
         ec = q_claim.pop_front(); ei = q_io.pop_front();
         ef = q_fn.pop_front();    t  = q_tag.pop_front();
         total++;
         if (claim !== ec || io_addr !== ei || func_num !== ef) begin
            bad++;
            $display("FAIL %s: claim=%0b io=%08h fn=%0d expected claim=%0b io=%08h fn=%0d",
                     t, claim, io_addr, func_num, ec, ei, ef);
         end
      end
   end

   task automatic drive_req(input logic v, input logic [35:0] a, input string tag);
      logic [31:0] eio;
      req_valid = v;
      req_addr  = a;
      eio = v ? {m_xl, a[15:0]} : m_hold;
      if (v) m_hold = eio;
      q_claim.push_back(v && (a[35:16] == m_base));
      q_io.push_back(eio);
      q_fn.push_back(m_fn);
      q_tag.push_back(tag);
   endtask

   task automatic do_req(input logic v, input logic [35:0] a, input string tag);
      @(posedge clk); #1;
      drive_req(v, a, tag);
   endtask

   // ends 1 time unit after the write edge, request inputs idle
   task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      req_valid = 1'b0;
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(posedge clk); #1;
      reg_we = 1'b0;
      if (a == 12'h300) begin m_base = d[31:12]; m_fn = d[2:0]; end
      else if (a == 12'h304) m_xl = d[31:16];
   endtask

   task automatic reg_check(input logic [11:0] a, input logic [31:0] exp, input string tag);
      @(posedge clk); #1;
      req_valid = 1'b0;
      reg_addr = a;
      @(negedge clk);
      total++;
      if (reg_rdata !== exp) begin
         bad++;
         $display("FAIL %s: rdata=%08h expected %08h", tag, reg_rdata, exp);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      total++;
      if (claim !== 1'b0 || io_addr !== 32'h0) begin
         bad++;
         $display("FAIL R6: claim=%0b io=%08h expected claim=0 io=00000000", claim, io_addr);
      end
      rst_n = 1'b1;

      reg_check(12'h300, 32'hFFFFD000, "R6 base reset");
      reg_check(12'h304, 32'h00000000, "R6 xlate reset");
      reg_check(12'h308, 32'h00000000, "R8 unmapped read");

      do_req(1'b1, 36'hF_FFFD_1234, "R1 R2 hit reset window");
      do_req(1'b1, 36'hF_FFFE_0000, "R1 miss next window");

      reg_write(12'h304, 32'hABCD_5678);
      reg_check(12'h304, 32'hABCD_0000, "R7 xlate low bits zero");

      reg_write(12'h300, 32'h1234_5FFD);
      drive_req(1'b1, 36'h1_2345_BEEF, "R10 R3 R4 request right after write");
      reg_check(12'h300, 32'h1234_5005, "R5 reserved bits dropped");

      do_req(1'b0, 36'h1_2345_0001, "R9 idle matching addr holds");
      do_req(1'b0, 36'h0_0000_0000, "R9 idle holds again");

      reg_write(12'h308, 32'hFFFF_FFFF);
      reg_check(12'h308, 32'h0, "R8 unmapped write read");
      reg_check(12'h300, 32'h1234_5005, "R8 base untouched");
      reg_check(12'h304, 32'hABCD_0000, "R8 xlate untouched");

      do_req(1'b1, 36'h1_2345_0000, "R1 R2 window first byte");
      do_req(1'b1, 36'h1_2345_FFFF, "R1 R2 window last byte");
      do_req(1'b1, 36'h1_2346_0000, "R1 R2 miss above window");
      do_req(1'b1, 36'h9_2345_0000, "R1 miss top bit differs");

      reg_write(12'h304, 32'h0001_FFFF);
      drive_req(1'b1, 36'h1_2345_00A5, "R10 R3 new xlate used at once");
      reg_write(12'h300, 32'h0000_0007);
      drive_req(1'b1, 36'h0_0000_4321, "R10 R4 new base and fn");
      do_req(1'b0, 36'h0, "R9 idle after change");

      @(posedge clk); #1;
      req_valid = 1'b0;
      repeat (2) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule